// File: doc/BRIEF.md
# Bit-Serial SIMD Processing Element

This block is one cell of a large single-bit SIMD array. Every cell in the array receives the same 20-bit instruction word on each clock. The cell holds four one-bit registers: two neighbour-exchange registers (NS and EW), a north-south shift register (CM) and a carry/borrow register (C). It also holds a 128-bit local store. A fixed full adder/subtracter reads NS, EW and C on every cycle. The instruction only steers the five source multiplexers and names one store address. Logic functions come from forcing one adder input to a constant. Multi-bit arithmetic runs one bit per cycle, with C carrying between consecutive store addresses.

The neighbour inputs and outputs are bare bits exchanged in lockstep on every clock. They are not streams, so there is no valid/ready handshake and no back-pressure. A neighbour sees each output bit the cycle after the register loads. An array controller, which lies outside this block, sequences the instructions and generates the addresses.

Top module: `bitproc_cell`

## Requirements
- R1: A synchronous reset, active high, clears NS, EW, CM and C to 0 on the next rising edge.
- R2: The instruction fields are: bits [19:17] NS source, [16:14] EW source, [13:11] C source, [10:9] CM source, [8:7] store-write source and [6:0] store address.
- R3: The adder computes sum = NS^EW^C, carry = majority(NS,EW,C) and borrow = (~NS&(EW|C))|(EW&C). For example, NS=0,EW=1,C=0 gives borrow 1, and NS=1,EW=0,C=1 gives borrow 0.
- R4: The NS source codes are 0 hold, 1 store bit, 2 north input, 3 south input, 4 EW, 5 zero, 6 one and 7 carry.
- R5: The EW source codes are 0 hold, 1 store bit, 2 east input, 3 west input, 4 NS, 5 zero, 6 one and 7 carry.
- R6: The C source codes are 0 hold, 1 store bit, 2 carry, 3 borrow, 4 zero and 5 one. Codes 6 and 7 hold.
- R7: The CM source codes are 0 hold, 1 store bit, 2 the CM input from the south and 3 zero. The cm_out pin shows CM.
- R8: The store-write codes are 0 no write, 1 sum, 2 carry and 3 CM. A write changes only the addressed bit.
- R9: An instruction that writes the store performs no read in the same cycle. Any register whose source is "store bit" in that instruction holds its value.
- R10: All register loads and the store write happen on the same rising edge and use pre-edge values. For example, NS<-EW together with EW<-NS swaps the two registers.
- R11: Loading operand bits into NS and EW while writing the sum and loading C from carry adds multi-bit operands one bit per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Array clock |
| rst | input | 1 | Synchronous reset, active high |
| instr | input | 20 | Broadcast instruction word |
| north_in | input | 1 | NS value of the north neighbour |
| south_in | input | 1 | NS value of the south neighbour |
| east_in | input | 1 | EW value of the east neighbour |
| west_in | input | 1 | EW value of the west neighbour |
| cm_in | input | 1 | CM value arriving from the south neighbour |
| ns_out | output | 1 | NS register, presented to north and south |
| ew_out | output | 1 | EW register, presented to east and west |
| cm_out | output | 1 | CM register, presented to the north |

## Verification
The three output pins are register outputs, so the effect of an instruction appears one rising edge after it is applied. The bench drives each instruction and its neighbour bits at a falling edge. It samples the outputs 1 ns after the next rising edge, the point at which a reference model, advanced once per instruction, holds the matching state. The adder results and the store are not visible directly and take extra cycles to bring out. A result is written to the store in one instruction and loaded into NS in the next, so it is checked on ns_out two edges after the instruction that produced it.

// File: rtl/bitproc_pkg.sv
package bitproc_pkg;
  localparam int unsigned PE_ADDR_W  = 7;
  localparam int unsigned PE_DEPTH   = 1 << PE_ADDR_W;
  localparam int unsigned PE_INSTR_W = 3 + 3 + 3 + 2 + 2 + PE_ADDR_W;

  typedef enum logic [2:0] {
    NS_HOLD, NS_MEM, NS_NORTH, NS_SOUTH, NS_EW, NS_ZERO, NS_ONE, NS_CARRY
  } ns_src_e;

  typedef enum logic [2:0] {
    EW_HOLD, EW_MEM, EW_EAST, EW_WEST, EW_NS, EW_ZERO, EW_ONE, EW_CARRY
  } ew_src_e;

  typedef enum logic [2:0] {
    C_HOLD, C_MEM, C_CARRY, C_BORROW, C_ZERO, C_ONE, C_SPARE6, C_SPARE7
  } c_src_e;

  typedef enum logic [1:0] {
    CM_HOLD, CM_MEM, CM_SOUTH, CM_ZERO
  } cm_src_e;

  typedef enum logic [1:0] {
    WR_NONE, WR_SUM, WR_CARRY, WR_CM
  } wr_src_e;

  typedef struct packed {
    ns_src_e               ns_src;
    ew_src_e               ew_src;
    c_src_e                c_src;
    cm_src_e               cm_src;
    wr_src_e               wr_src;
    logic [PE_ADDR_W-1:0]  addr;
  } op_t;

  typedef struct packed {
    logic ns;
    logic ew;
    logic c;
    logic cm;
  } pe_regs_t;
endpackage

// File: rtl/bitproc_alu.sv
module bitproc_alu (
  input  logic ns,
  input  logic ew,
  input  logic c,
  output logic sum,
  output logic carry,
  output logic borrow
);
  assign sum    = ns ^ ew ^ c;
  assign carry  = (ns & ew) | (ns & c) | (ew & c);
  assign borrow = (~ns & (ew | c)) | (ew & c);

  always_comb begin
    if (ns == ew && ew == c) begin
      assert_equal_inputs_R3: assert (sum == ns && carry == ns);
    end
    if (!ns && ew && c) begin
      assert_full_borrow_R3: assert (borrow && carry && !sum);
    end
  end
endmodule

// File: rtl/bitproc_bitmem.sv
module bitproc_bitmem #(
  parameter int unsigned AW = 7
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic          wd,
  output logic          rd
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DEPTH-1:0] bits;

  for (genvar i = 0; i < DEPTH; i++) begin : g_cell
    always_ff @(posedge clk) begin
      if (we && addr == AW'(i)) bits[i] <= wd;
    end
  end

  assign rd = bits[addr];

  property p_store_lands;
    @(posedge clk) we |=> bits[$past(addr)] == $past(wd);
  endproperty
  assert_store_lands_R8: assert property (p_store_lands);
endmodule

// File: rtl/bitproc_srcsel.sv
module bitproc_srcsel
  import bitproc_pkg::*;
(
  input  op_t      op,
  input  pe_regs_t cur,
  input  logic     mem_rd,
  input  logic     sum,
  input  logic     carry,
  input  logic     borrow,
  input  logic     north_in,
  input  logic     south_in,
  input  logic     east_in,
  input  logic     west_in,
  input  logic     cm_in,
  output pe_regs_t nxt,
  output logic     mem_we,
  output logic     mem_wd
);
  logic rd_ok;
  assign rd_ok = (op.wr_src == WR_NONE);

  always_comb begin
    unique case (op.ns_src)
      NS_HOLD:  nxt.ns = cur.ns;
      NS_MEM:   nxt.ns = rd_ok ? mem_rd : cur.ns;
      NS_NORTH: nxt.ns = north_in;
      NS_SOUTH: nxt.ns = south_in;
      NS_EW:    nxt.ns = cur.ew;
      NS_ZERO:  nxt.ns = 1'b0;
      NS_ONE:   nxt.ns = 1'b1;
      default:  nxt.ns = carry;
    endcase

    unique case (op.ew_src)
      EW_HOLD:  nxt.ew = cur.ew;
      EW_MEM:   nxt.ew = rd_ok ? mem_rd : cur.ew;
      EW_EAST:  nxt.ew = east_in;
      EW_WEST:  nxt.ew = west_in;
      EW_NS:    nxt.ew = cur.ns;
      EW_ZERO:  nxt.ew = 1'b0;
      EW_ONE:   nxt.ew = 1'b1;
      default:  nxt.ew = carry;
    endcase

    unique case (op.c_src)
      C_MEM:    nxt.c = rd_ok ? mem_rd : cur.c;
      C_CARRY:  nxt.c = carry;
      C_BORROW: nxt.c = borrow;
      C_ZERO:   nxt.c = 1'b0;
      C_ONE:    nxt.c = 1'b1;
      default:  nxt.c = cur.c;
    endcase

    unique case (op.cm_src)
      CM_HOLD:  nxt.cm = cur.cm;
      CM_MEM:   nxt.cm = rd_ok ? mem_rd : cur.cm;
      CM_SOUTH: nxt.cm = cm_in;
      default:  nxt.cm = 1'b0;
    endcase

    unique case (op.wr_src)
      WR_SUM:   mem_wd = sum;
      WR_CARRY: mem_wd = carry;
      WR_CM:    mem_wd = cur.cm;
      default:  mem_wd = 1'b0;
    endcase
  end

  assign mem_we = !rd_ok;
endmodule

// File: rtl/bitproc_cell.sv
module bitproc_cell
  import bitproc_pkg::*;
#(
  parameter int unsigned ADDR_BITS = PE_ADDR_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [PE_INSTR_W-1:0] instr,
  input  logic                  north_in,
  input  logic                  south_in,
  input  logic                  east_in,
  input  logic                  west_in,
  input  logic                  cm_in,
  output logic                  ns_out,
  output logic                  ew_out,
  output logic                  cm_out
);
  op_t      op;
  pe_regs_t cur, nxt;
  logic     alu_sum, alu_carry, alu_borrow;
  logic     mem_rd, mem_we, mem_wd;

  assign op = op_t'(instr);

  bitproc_alu u_alu (
    .ns(cur.ns), .ew(cur.ew), .c(cur.c),
    .sum(alu_sum), .carry(alu_carry), .borrow(alu_borrow)
  );

  bitproc_srcsel u_sel (
    .op(op), .cur(cur), .mem_rd(mem_rd),
    .sum(alu_sum), .carry(alu_carry), .borrow(alu_borrow),
    .north_in(north_in), .south_in(south_in),
    .east_in(east_in), .west_in(west_in), .cm_in(cm_in),
    .nxt(nxt), .mem_we(mem_we), .mem_wd(mem_wd)
  );

  bitproc_bitmem #(.AW(ADDR_BITS)) u_mem (
    .clk(clk), .we(mem_we), .addr(op.addr[ADDR_BITS-1:0]),
    .wd(mem_wd), .rd(mem_rd)
  );

  always_ff @(posedge clk) begin
    if (rst) cur <= '0;
    else     cur <= nxt;
  end

  assign ns_out = cur.ns;
  assign ew_out = cur.ew;
  assign cm_out = cur.cm;

  property p_reset_clears;
    @(posedge clk) rst |=> (cur == '0);
  endproperty
  assert_reset_clears_R1: assert property (p_reset_clears);

  property p_ns_north;
    @(posedge clk) disable iff (rst)
      (op.ns_src == NS_NORTH) |=> (ns_out == $past(north_in));
  endproperty
  assert_ns_north_R4: assert property (p_ns_north);

  property p_ew_from_ns;
    @(posedge clk) disable iff (rst)
      (op.ew_src == EW_NS) |=> (ew_out == $past(ns_out));
  endproperty
  assert_ew_takes_old_ns_R10: assert property (p_ew_from_ns);

  property p_c_hold;
    @(posedge clk) disable iff (rst)
      (op.c_src == C_HOLD) |=> $stable(cur.c);
  endproperty
  assert_c_hold_R6: assert property (p_c_hold);

  property p_cm_south;
    @(posedge clk) disable iff (rst)
      (op.cm_src == CM_SOUTH) |=> (cm_out == $past(cm_in));
  endproperty
  assert_cm_south_R7: assert property (p_cm_south);

  property p_no_read_on_write;
    @(posedge clk) disable iff (rst)
      (op.wr_src != WR_NONE && op.ns_src == NS_MEM) |=> $stable(ns_out);
  endproperty
  assert_no_read_on_write_R9: assert property (p_no_read_on_write);
endmodule

// File: tb/bitproc_cell_test.sv
`timescale 1ns/1ps
module bitproc_cell_test;
  logic        clk = 1'b0;
  logic        rst;
  logic [19:0] instr;
  logic        north_in, south_in, east_in, west_in, cm_in;
  logic        ns_out, ew_out, cm_out;

  int checks = 0;
  int fails  = 0;

  logic m_ns, m_ew, m_cm, m_c;
  logic m_mem [128];

  always #2.5 clk = ~clk;

  bitproc_cell uut (
    .clk(clk), .rst(rst), .instr(instr),
    .north_in(north_in), .south_in(south_in),
    .east_in(east_in), .west_in(west_in), .cm_in(cm_in),
    .ns_out(ns_out), .ew_out(ew_out), .cm_out(cm_out)
  );

  function automatic logic [19:0] mk(int ns, int ew, int c, int cm, int wr, int a);
    logic [19:0] w;
    w = {ns[2:0], ew[2:0], c[2:0], cm[1:0], wr[1:0], a[6:0]};
    return w;
  endfunction

  task automatic check(string tag, logic [2:0] act, logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // applies one instruction, advances the reference model, checks {ns,ew,cm}
  task automatic step(logic [19:0] ins, string tag, int cmv = -1);
    logic s, cy, bw, rd, wr_on;
    logic n_ns, n_ew, n_cm, n_c;
    int a;
    @(negedge clk);
    instr    = ins;
    north_in = 1'($urandom);
    south_in = 1'($urandom);
    east_in  = 1'($urandom);
    west_in  = 1'($urandom);
    cm_in    = (cmv < 0) ? 1'($urandom) : 1'(cmv);
    a     = int'(ins[6:0]);
    s     = m_ns ^ m_ew ^ m_c;
    cy    = (m_ns & m_ew) | (m_ns & m_c) | (m_ew & m_c);
    bw    = (~m_ns & (m_ew | m_c)) | (m_ew & m_c);
    rd    = m_mem[a];
    wr_on = (ins[8:7] != 2'd0);
    case (ins[19:17])
      3'd0: n_ns = m_ns;       3'd1: n_ns = wr_on ? m_ns : rd;
      3'd2: n_ns = north_in;   3'd3: n_ns = south_in;
      3'd4: n_ns = m_ew;       3'd5: n_ns = 1'b0;
      3'd6: n_ns = 1'b1;       default: n_ns = cy;
    endcase
    case (ins[16:14])
      3'd0: n_ew = m_ew;       3'd1: n_ew = wr_on ? m_ew : rd;
      3'd2: n_ew = east_in;    3'd3: n_ew = west_in;
      3'd4: n_ew = m_ns;       3'd5: n_ew = 1'b0;
      3'd6: n_ew = 1'b1;       default: n_ew = cy;
    endcase
    case (ins[13:11])
      3'd1: n_c = wr_on ? m_c : rd;
      3'd2: n_c = cy;          3'd3: n_c = bw;
      3'd4: n_c = 1'b0;        3'd5: n_c = 1'b1;
      default: n_c = m_c;
    endcase
    case (ins[10:9])
      2'd0: n_cm = m_cm;       2'd1: n_cm = wr_on ? m_cm : rd;
      2'd2: n_cm = cm_in;      default: n_cm = 1'b0;
    endcase
    case (ins[8:7])
      2'd1: m_mem[a] = s;
      2'd2: m_mem[a] = cy;
      2'd3: m_mem[a] = m_cm;
      default: ;
    endcase
    m_ns = n_ns; m_ew = n_ew; m_cm = n_cm; m_c = n_c;
    @(posedge clk);
    #1;
    check(tag, {ns_out, ew_out, cm_out}, {m_ns, m_ew, m_cm});
  endtask

  // probe: write sum of (0,0,C) to addr 127, pull it into NS; returns C
  task automatic read_c(string tag, logic exp_c);
    step(mk(5, 5, 0, 0, 0, 0), tag);
    step(mk(0, 0, 0, 0, 1, 127), tag);
    step(mk(1, 0, 0, 0, 0, 127), tag);
    check(tag, {2'b00, ns_out}, {2'b00, exp_c});
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int a_v, b_v, r_v;
    void'($urandom(32'h5eed_0042));
    instr = '0;
    north_in = 0; south_in = 0; east_in = 0; west_in = 0; cm_in = 0;
    rst = 1'b1;
    m_ns = 0; m_ew = 0; m_cm = 0; m_c = 0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset outputs", {ns_out, ew_out, cm_out}, 3'b000);
    @(negedge clk);
    rst = 1'b0;

    // clear the store through CM (R7, R8)
    step(mk(0, 0, 0, 3, 0, 0), "R7 cm zero");
    for (int i = 0; i < 128; i++) step(mk(0, 0, 0, 0, 3, i), "R8 clear");
    read_c("R1 C cleared by reset", 1'b0);

    // R10: swap NS and EW on one edge
    step(mk(6, 5, 0, 0, 0, 0), "R4 ns one");
    step(mk(4, 4, 0, 0, 0, 0), "R10 swap");
    check("R10 swap result", {ns_out, ew_out, 1'b0}, 3'b010);

    // R3: NS=1, EW=0, C=1 -> borrow 0
    step(mk(6, 5, 5, 0, 0, 0), "R6 c one");
    step(mk(0, 0, 3, 0, 0, 0), "R6 c borrow");
    read_c("R3 borrow 101", 1'b0);
    // R3: NS=0, EW=1, C=0 -> borrow 1
    step(mk(5, 6, 4, 0, 0, 0), "R5 ew one");
    step(mk(0, 0, 3, 0, 0, 0), "R6 c borrow");
    read_c("R3 borrow 010", 1'b1);

    // R9: store write blocks a register's store read
    step(mk(6, 0, 0, 2, 0, 0), "R7 cm south", 1);
    step(mk(0, 0, 0, 0, 3, 40), "R8 cm to store");
    step(mk(5, 0, 0, 0, 0, 0), "R4 ns zero");
    step(mk(1, 1, 0, 0, 1, 40), "R9 read suppressed");
    check("R9 ns held", {ns_out, ew_out, 1'b0}, {1'b0, m_ew, 1'b0});
    step(mk(1, 0, 0, 0, 0, 40), "R8 read back");

    // R11: 4-bit bit-serial additions
    for (int t = 0; t < 6; t++) begin
      a_v = (t == 0) ? 15 : (t == 1) ? 0 : int'($urandom % 16);
      b_v = (t == 0) ? 15 : (t == 1) ? 9 : int'($urandom % 16);
      for (int i = 0; i < 4; i++) begin
        step(mk(0, 0, 0, 2, 0, 0), "R7 load a", (a_v >> i) & 1);
        step(mk(0, 0, 0, 0, 3, i), "R8 store a");
        step(mk(0, 0, 0, 2, 0, 0), "R7 load b", (b_v >> i) & 1);
        step(mk(0, 0, 0, 0, 3, 4 + i), "R8 store b");
      end
      step(mk(0, 0, 4, 0, 0, 0), "R6 c zero");
      for (int i = 0; i < 4; i++) begin
        step(mk(1, 0, 0, 0, 0, i), "R11 fetch a");
        step(mk(0, 1, 0, 0, 0, 4 + i), "R11 fetch b");
        step(mk(0, 0, 2, 0, 1, 8 + i), "R11 sum");
      end
      step(mk(6, 5, 0, 0, 0, 0), "R11 prep carry");
      step(mk(0, 0, 0, 0, 2, 12), "R11 carry out");
      r_v = a_v + b_v;
      for (int i = 0; i < 5; i++) begin
        step(mk(1, 0, 0, 0, 0, 8 + i), "R11 read");
        check("R11 add bit", {2'b00, ns_out}, {2'b00, 1'((r_v >> i) & 1)});
      end
    end

    // R2..R8: random instruction mix against the model
    for (int k = 0; k < 4000; k++) begin
      step(20'($urandom), "R2 random");
    end

    // R1: reset mid-run
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #1;
    check("R1 mid-run reset", {ns_out, ew_out, cm_out}, 3'b000);
    @(negedge clk);
    rst = 1'b0;
    m_ns = 0; m_ew = 0; m_cm = 0; m_c = 0;
    read_c("R1 C after reset", 1'b0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule